// File: doc/BRIEF.md
# Card Transmit FIFO with Burst Request Pacing

This block is the outbound data buffer of a memory-card host controller. It holds 16-bit words in a FIFO. The system DMA or the local host fills it through a single write port, and the card data path empties it one word per read strobe. The read side is show-ahead: the word at the head is always present on `rdData`.

During a block write the block paces the system DMA with a request line. A block-write command arms the block. From then on, whenever no burst is outstanding and the fill level has fallen to the almost-empty threshold or below, the block raises a request. The request drops once the first word of the burst has been written. No further request is raised until every word of that burst has arrived. The intended setting is threshold = burst − 1 with a burst of at most half the FIFO depth, so two bursts can share the FIFO.

While the FIFO is empty the card clock enable is held low, which stalls the card path until fresh data is written. The FIFO therefore never underflows. A synchronous reset or a transfer-complete strobe empties the FIFO and returns all pacing state to idle.

Top module: `card_tx_dreq`

## Requirements
- R1: After `rst` or `xferDone` the fill level is 0, `dmaReq` is 0, `overflow` is 0 and the block is disarmed; when `xferDone` and `wrCmd` coincide, the clear wins.
- R2: Words leave in the order they were accepted, 16 bits wide, and `rdData` shows the oldest stored word whenever the FIFO is not empty.
- R3: A write while the fill level equals the depth (32 by default) is dropped, and it sets `overflow`, which stays set until the next clear.
- R4: A read strobe while the FIFO is empty has no effect, and the fill level never goes below 0.
- R5: `dmaReq` never rises unless a `wrCmd` has been seen since the last clear, regardless of the fill level.
- R6: When the block is armed, no burst is outstanding and `fillLevel <= aeLevel`, `dmaReq` is 1 in the next cycle.
- R7: While `dmaReq` is 1, the first accepted write lowers it in the next cycle, so a request spans a single word write.
- R8: Once a request has been raised, no new request is raised until n accepted writes have completed the burst, even if the level stays at or below the threshold.
- R9: `cardClkEn` is 0 exactly while the fill level is 0, and it returns to 1 in the cycle after a write is accepted into the empty FIFO.
- R10: `fillLevel` rises by one for each accepted write and falls by one for each accepted read, and it is unchanged when both are accepted in the same cycle.
- R11: The burst length n is `burstSize` interpreted as an unsigned value. A value of 0 is treated as 1, and values above 16 are treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xferDone | input | 1 | Transfer-complete strobe: clears FIFO and pacing state |
| wrCmd | input | 1 | Block-write command strobe: arms request generation |
| aeLevel | input | 6 | Almost-empty threshold in words |
| burstSize | input | 5 | DMA burst length n in words |
| wrEn | input | 1 | Word write strobe (DMA or local host) |
| wrData | input | 16 | Word to write |
| rdEn | input | 1 | Read strobe from the card data path |
| rdData | output | 16 | Head word of the FIFO |
| fillLevel | output | 6 | Number of stored words |
| dmaReq | output | 1 | Request to the system DMA |
| cardClkEn | output | 1 | Card clock enable, low while empty |
| overflow | output | 1 | Sticky flag for a write dropped while full |

## Verification
The hardest condition to reach is the lockout of R8. In that state a burst is partly written and the level already meets the threshold, but a request is still forbidden. A well-behaved DMA never leaves the block there for long. The bench therefore answers a request with a single word and then idles before it finishes the burst, and a later phase runs a responder that writes at its own pace against a reader that drains with an irregular pattern. Overflow is reached by host writes that ignore the pacing entirely. A reference model is compared against the design on every cycle throughout.

// File: rtl/cardtx_pkg.sv
package cardtx_pkg;

  localparam int WORD_W = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // store wrData at the tail
    logic pop;    // drop the head word
    logic clear;  // empty the FIFO
  } fifoStrobe_t;

endpackage

// File: rtl/cardtx_fifo.sv
module cardtx_fifo
  import cardtx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] headData,
  output logic [LVLW-1:0]   level,
  output logic              full,
  output logic              empty
);

  localparam logic [LVLW-1:0] LVL_FULL = LVLW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign full     = (level == LVL_FULL);
  assign empty    = (level == '0);

  // R4: an empty FIFO stays empty without a write
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && !strb.push && !strb.clear) |=> (level == '0));

  // R3: a full FIFO stays full without a read
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (level == LVL_FULL && !strb.pop && !strb.clear) |=> (level == LVL_FULL));

  // R10: simultaneous push and pop keep the level
  a_r10_level_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.push && strb.pop && !strb.clear) |=> $stable(level));

endmodule

// File: rtl/cardtx_ctrl.sv
module cardtx_ctrl
  import cardtx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int MAX_BURST = 16,
  localparam int LVLW     = $clog2(DEPTH + 1),
  localparam int BURSTW   = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xferDone,
  input  logic              wrCmd,
  input  logic [LVLW-1:0]   aeLevel,
  input  logic [4:0]        burstSize,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [LVLW-1:0]   level,
  input  logic              full,
  input  logic              empty,
  output fifoStrobe_t       strb,
  output logic              dmaReq,
  output logic              cardClkEn,
  output logic              overflow
);

  logic              armed;
  logic [BURSTW-1:0] burstCnt;
  logic [BURSTW-1:0] burstLen;
  logic              wrAccept;

  // Clamp the programmed burst length into 1..MAX_BURST
  always_comb begin
    if (burstSize == '0)
      burstLen = BURSTW'(1);
    else if (32'(burstSize) > MAX_BURST)
      burstLen = BURSTW'(MAX_BURST);
    else
      burstLen = BURSTW'(burstSize);
  end

  assign wrAccept   = wrEn && !full;
  assign strb.push  = wrAccept;
  assign strb.pop   = rdEn && !empty;
  assign strb.clear = xferDone;
  assign cardClkEn  = !empty;

  always_ff @(posedge clk) begin
    if (rst || xferDone) begin
      armed    <= 1'b0;
      dmaReq   <= 1'b0;
      burstCnt <= '0;
      overflow <= 1'b0;
    end else begin
      if (wrCmd)        armed    <= 1'b1;
      if (wrEn && full) overflow <= 1'b1;
      if (dmaReq) begin
        if (wrAccept) begin
          dmaReq   <= 1'b0;
          burstCnt <= burstCnt - 1'b1;
        end
      end else if (armed && burstCnt == '0 && level <= aeLevel) begin
        dmaReq   <= 1'b1;
        burstCnt <= burstLen;
      end else if (wrAccept && burstCnt != '0) begin
        burstCnt <= burstCnt - 1'b1;
      end
    end
  end

  // R1: transfer complete drops request and flag
  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    xferDone |=> (!dmaReq && !overflow));

  // R5: a request only rises from the armed state
  a_r5_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(dmaReq) |-> $past(armed));

  // R7: a request lasts until the first accepted write
  a_r7_one_word: assert property (@(posedge clk) disable iff (rst || xferDone)
    (dmaReq && wrAccept) |=> !dmaReq);

  // R8: no new request while a burst is outstanding
  a_r8_lockout: assert property (@(posedge clk) disable iff (rst)
    (burstCnt != '0 && !dmaReq) |=> !dmaReq);

  // R9: the card path cannot read while its clock is stopped
  a_r9_clock_stall: assert property (@(posedge clk) disable iff (rst)
    !cardClkEn |-> !strb.pop);

endmodule

// File: rtl/card_tx_dreq.sv
module card_tx_dreq
  import cardtx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int MAX_BURST = 16,
  localparam int LVLW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xferDone,
  input  logic              wrCmd,
  input  logic [LVLW-1:0]   aeLevel,
  input  logic [4:0]        burstSize,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic [LVLW-1:0]   fillLevel,
  output logic              dmaReq,
  output logic              cardClkEn,
  output logic              overflow
);

  fifoStrobe_t strb;
  logic        full;
  logic        empty;

  cardtx_ctrl #(.DEPTH(DEPTH), .MAX_BURST(MAX_BURST)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .xferDone  (xferDone),
    .wrCmd     (wrCmd),
    .aeLevel   (aeLevel),
    .burstSize (burstSize),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .level     (fillLevel),
    .full      (full),
    .empty     (empty),
    .strb      (strb),
    .dmaReq    (dmaReq),
    .cardClkEn (cardClkEn),
    .overflow  (overflow)
  );

  cardtx_fifo #(.DEPTH(DEPTH)) uFifo (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (wrData),
    .headData (rdData),
    .level    (fillLevel),
    .full     (full),
    .empty    (empty)
  );

endmodule

// File: tb/sim_card_tx_dreq.sv
module sim_card_tx_dreq;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xferDone = 1'b0;
  logic        wrCmd = 1'b0;
  logic [5:0]  aeLevel = 6'd3;
  logic [4:0]  burstSize = 5'd4;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [5:0]  fillLevel;
  logic        dmaReq;
  logic        cardClkEn;
  logic        overflow;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_tx_dreq u0 (
    .clk(clk), .rst(rst), .xferDone(xferDone), .wrCmd(wrCmd),
    .aeLevel(aeLevel), .burstSize(burstSize), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .fillLevel(fillLevel), .dmaReq(dmaReq),
    .cardClkEn(cardClkEn), .overflow(overflow)
  );

  // Behavioural reference model
  logic [15:0] q[$];
  bit mArmed, mReq, mOvf;
  int mCnt;

  always @(posedge clk) begin
    int n;
    bit push, pop, nReq, nArmed;
    int nCnt;
    cyc++;
    if (rst || xferDone) begin
      q.delete();
      mArmed = 0; mReq = 0; mOvf = 0; mCnt = 0;
    end else begin
      n = (burstSize == 0) ? 1 : ((burstSize > 16) ? 16 : int'(burstSize));
      push = wrEn && (q.size() < DEPTH);
      pop  = rdEn && (q.size() > 0);
      if (wrEn && q.size() == DEPTH) mOvf = 1;
      nReq = mReq; nCnt = mCnt; nArmed = mArmed || wrCmd;
      if (mReq) begin
        if (push) begin nReq = 0; nCnt = mCnt - 1; end
      end else if (mArmed && mCnt == 0 && q.size() <= int'(aeLevel)) begin
        nReq = 1; nCnt = n;
      end else if (push && mCnt != 0) begin
        nCnt = mCnt - 1;
      end
      if (pop) void'(q.pop_front());
      if (push) q.push_back(wrData);
      mReq = nReq; mCnt = nCnt; mArmed = nArmed;
    end
    started = 1;
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk(fillLevel, q.size(), "R10 fillLevel");
      chk(dmaReq, mReq, "R6 R7 R8 dmaReq");
      chk(cardClkEn, q.size() != 0, "R9 cardClkEn");
      chk(overflow, mOvf, "R3 overflow");
      if (q.size() > 0) chk(rdData, q[0], "R2 rdData head");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic idle(input int k);
    wrEn = 0; rdEn = 0; wrCmd = 0; xferDone = 0;
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic put(input logic [15:0] d);
    wrEn = 1; wrData = d; tick(); wrEn = 0;
  endtask

  task automatic take();
    rdEn = 1; tick(); rdEn = 0;
  endtask

  logic [15:0] seed = 16'hACE1;

  initial begin
    int pending;
    tick(); tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(fillLevel, 0, "R1 level after reset");
    chk(dmaReq, 0, "R1 dmaReq after reset");
    chk(overflow, 0, "R1 overflow after reset");
    chk(cardClkEn, 0, "R9 empty after reset");

    // R5 unarmed: empty FIFO below threshold, still no request
    idle(5);
    chk(dmaReq, 0, "R5 no request before command");

    // Arm: request appears two edges later
    wrCmd = 1; tick(); wrCmd = 0;
    tick();
    chk(dmaReq, 1, "R6 request after arming");

    // R7: one word lowers the request; R8: then idle with level 1 <= 3
    put(16'h1111);
    chk(dmaReq, 0, "R7 request dropped after one word");
    idle(6);
    chk(dmaReq, 0, "R8 lockout while burst incomplete");
    put(16'h2222); put(16'h3333); put(16'h4444);
    idle(2);
    chk(fillLevel, 4, "R10 four words stored");
    chk(dmaReq, 0, "R6 level 4 above threshold");

    // R2 order, drain two words then a request follows
    chk(rdData, 16'h1111, "R2 first head");
    take();
    chk(rdData, 16'h2222, "R2 second head");
    take();
    tick();
    chk(dmaReq, 1, "R6 request after draining to threshold");
    // R10 simultaneous read and write
    rdEn = 1; wrEn = 1; wrData = 16'h5555; tick(); rdEn = 0; wrEn = 0;
    chk(fillLevel, 2, "R10 level unchanged on read+write");
    put(16'h6666); put(16'h7777); put(16'h8888);
    idle(2);

    // R3 fill to full with host writes, overflow
    for (int i = 0; i < 34; i++) put(16'hA000 + 16'(i));
    idle(1);
    chk(fillLevel, DEPTH, "R3 level at depth");
    chk(overflow, 1, "R3 overflow set");
    idle(3);
    chk(overflow, 1, "R3 overflow sticky");

    // R4 drain past empty
    for (int i = 0; i < DEPTH + 3; i++) take();
    idle(1);
    chk(fillLevel, 0, "R4 no underflow");
    chk(cardClkEn, 0, "R9 clock stopped when empty");
    idle(8);

    // R1 transfer complete with wrCmd in the same cycle
    xferDone = 1; wrCmd = 1; tick(); xferDone = 0; wrCmd = 0;
    idle(4);
    chk(dmaReq, 0, "R1 disarmed after xferDone");
    chk(overflow, 0, "R1 overflow cleared");

    // R11 burst size 0 acts as 1, threshold 0
    aeLevel = 0; burstSize = 0;
    wrCmd = 1; tick(); wrCmd = 0;
    tick();
    chk(dmaReq, 1, "R11 request with burst 0");
    put(16'hBEEF);
    idle(3);
    chk(dmaReq, 0, "R11 level 1 above threshold");
    chk(cardClkEn, 1, "R9 clock running with data");
    take();
    tick();
    chk(dmaReq, 1, "R11 burst of one completed, new request");
    put(16'hCAFE); idle(2);

    // R11 oversize burst clamps to 16 and the streaming run
    xferDone = 1; tick(); xferDone = 0;
    aeLevel = 6'd15; burstSize = 5'd31;
    wrCmd = 1; tick(); wrCmd = 0;
    pending = 0;
    for (int i = 0; i < 600; i++) begin
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      if (dmaReq && pending == 0) pending = 16;
      wrEn = (pending > 0) && seed[0];
      wrData = seed;
      rdEn = seed[3] | seed[5];
      tick();
      if (wrEn && pending > 0) pending--;
    end
    wrEn = 0; rdEn = 0;
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule